// File: doc/BRIEF.md
# Dual-Rail Select-Driven Merge Stage

This block joins two dual-rail data channels onto a single dual-rail output channel. A third channel, the select channel, carries a one-bit token on two rails and decides which data channel supplies the next output token. Every channel uses a four-phase return-to-zero handshake. The stage follows a precharge-half-buffer discipline, modelled here as clocked logic with registered outputs. It consumes a token only when the output channel has returned to idle. It resets its output only after the receiver acknowledges. It lowers its input acknowledges only after the output is neutral again.

Only the data channel that was read, together with the select channel, is acknowledged. The other data channel is never touched, so a token waiting there stays until a later select token picks it. After the output reset, the stage waits for the select channel and the chosen data channel to return to neutral. The two waits are independent, and each acknowledge drops as soon as its own channel is neutral. The stage then arms for the next token once both acknowledges are low.

Top module: `dr_merge_stage`

## Requirements
- R1: While and right after reset, `sel_ack`, `a_ack` and `b_ack` are 0 and both output rail vectors `y_t`/`y_f` are all zero (neutral).
- R2: While `y_ack` is high the stage accepts no token: the output stays neutral and all acknowledges stay low, even with valid select and data tokens present.
- R3: A token is accepted only when the select channel is valid (exactly one of `sel_rail[1:0]` high) and the chosen data channel is complete (every bit has exactly one of its true/false rails high). A partly arrived data token or a neutral select produces no output.
- R4: With `sel_rail[0]` high the token on channel A is copied to the output. With `sel_rail[1]` high the token on channel B is copied. The output becomes valid one clock after the acceptance conditions hold, with `y_t` carrying the data bits and `y_f` their complement.
- R5: One clock after the output becomes valid, the acknowledge of the chosen data channel and `sel_ack` rise together. Before that clock, both are low.
- R6: The acknowledge of the data channel that was not selected stays low for the whole handshake, even while that channel holds a valid token. That token is delivered later, in order, when a select token picks its channel.
- R7: The output stays valid while `y_ack` is low. One clock after `y_ack` is seen high, the output returns to neutral.
- R8: The chosen data acknowledge falls only after the output is neutral and that data channel is neutral.
- R9: `sel_ack` falls once both select rails are low and the output is neutral, independently of whether the data channel has returned to neutral.
- R10: A new token is accepted only after both the select and the chosen data acknowledge are low again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_rail | input | 2 | Select token rails: bit 0 picks channel A, bit 1 picks channel B |
| sel_ack | output | 1 | Select channel acknowledge |
| a_t | input | W | Channel A true rails |
| a_f | input | W | Channel A false rails |
| a_ack | output | 1 | Channel A acknowledge |
| b_t | input | W | Channel B true rails |
| b_f | input | W | Channel B false rails |
| b_ack | output | 1 | Channel B acknowledge |
| y_t | output | W | Output true rails |
| y_f | output | W | Output false rails |
| y_ack | input | 1 | Output channel acknowledge from the receiver |

## Verification
The hardest state to reach from the ports is a split return-to-zero, where `sel_ack` has already fallen but the chosen data acknowledge is still held high because its data rails remain valid. The stimulus reaches it by releasing only the select rails before acknowledging the output. It then keeps the data token asserted for several cycles before releasing it. A second demanding case is a valid token that waits on the unselected channel across several handshakes. The select stream is chosen so that each channel repeatedly holds a token while the other one is being served, and the output order is compared against a reference merge built from the two data streams.

// File: rtl/dr_merge_pkg.sv
package dr_merge_pkg;

  typedef enum logic [1:0] {
    ST_ARM  = 2'd0,
    ST_ACK  = 2'd1,
    ST_HOLD = 2'd2,
    ST_RTZ  = 2'd3
  } mrg_state_e;

  typedef enum logic {
    PICK_A = 1'b0,
    PICK_B = 1'b1
  } pick_e;

endpackage

// File: rtl/dr_rail_detect.sv
module dr_rail_detect #(
  parameter int W = 4
) (
  input  logic [W-1:0] t_i,
  input  logic [W-1:0] f_i,
  output logic         full_o,
  output logic         empty_o
);

  logic [W-1:0] bit_done;
  logic [W-1:0] bit_idle;

  genvar gi;
  generate
    for (gi = 0; gi < W; gi++) begin : g_bit
      assign bit_done[gi] = t_i[gi] ^ f_i[gi];
      assign bit_idle[gi] = ~(t_i[gi] | f_i[gi]);
    end
  endgenerate

  assign full_o  = &bit_done;
  assign empty_o = &bit_idle;

endmodule

// File: rtl/dr_ack_unit.sv
module dr_ack_unit (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic ack_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_o <= 1'b0;
    end else if (set_i) begin
      ack_o <= 1'b1;
    end else if (clr_i) begin
      ack_o <= 1'b0;
    end
  end

endmodule

// File: rtl/dr_merge_fsm.sv
module dr_merge_fsm
  import dr_merge_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic sel_valid,
  input  logic sel_pick_b,
  input  logic sel_empty,
  input  logic a_full,
  input  logic a_empty,
  input  logic b_full,
  input  logic b_empty,
  input  logic y_ack,
  input  logic sel_ack_q,
  input  logic a_ack_q,
  input  logic b_ack_q,
  output logic load_o,
  output logic clear_o,
  output logic pick_o,
  output logic set_s_o,
  output logic set_a_o,
  output logic set_b_o,
  output logic clr_s_o,
  output logic clr_a_o,
  output logic clr_b_o
);

  mrg_state_e state_q, state_d;
  pick_e      pick_q;
  logic       chosen_full;
  logic       s_done, d_done;

  assign chosen_full = sel_pick_b ? b_full : a_full;
  assign pick_o      = (pick_q == PICK_B);

  always_comb begin
    state_d = state_q;
    load_o  = 1'b0;
    clear_o = 1'b0;
    set_s_o = 1'b0;
    set_a_o = 1'b0;
    set_b_o = 1'b0;
    clr_s_o = 1'b0;
    clr_a_o = 1'b0;
    clr_b_o = 1'b0;
    s_done  = 1'b0;
    d_done  = 1'b0;
    case (state_q)
      ST_ARM: begin
        if (!y_ack && sel_valid && chosen_full) begin
          load_o  = 1'b1;
          state_d = ST_ACK;
        end
      end
      ST_ACK: begin
        set_s_o = 1'b1;
        set_a_o = (pick_q == PICK_A);
        set_b_o = (pick_q == PICK_B);
        state_d = ST_HOLD;
      end
      ST_HOLD: begin
        if (y_ack) begin
          clear_o = 1'b1;
          state_d = ST_RTZ;
        end
      end
      ST_RTZ: begin
        clr_s_o = sel_ack_q && sel_empty;
        clr_a_o = (pick_q == PICK_A) && a_ack_q && a_empty;
        clr_b_o = (pick_q == PICK_B) && b_ack_q && b_empty;
        s_done  = !sel_ack_q || clr_s_o;
        d_done  = (pick_q == PICK_A) ? (!a_ack_q || clr_a_o)
                                     : (!b_ack_q || clr_b_o);
        if (s_done && d_done) begin
          state_d = ST_ARM;
        end
      end
      default: state_d = ST_ARM;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_ARM;
      pick_q  <= PICK_A;
    end else begin
      state_q <= state_d;
      if (load_o) begin
        pick_q <= sel_pick_b ? PICK_B : PICK_A;
      end
    end
  end

endmodule

// File: rtl/dr_out_reg.sv
module dr_out_reg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic         clear_i,
  input  logic         pick_b_i,
  input  logic [W-1:0] a_t,
  input  logic [W-1:0] a_f,
  input  logic [W-1:0] b_t,
  input  logic [W-1:0] b_f,
  output logic [W-1:0] y_t,
  output logic [W-1:0] y_f
);

  logic [W-1:0] mux_t, mux_f;

  assign mux_t = pick_b_i ? b_t : a_t;
  assign mux_f = pick_b_i ? b_f : a_f;

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      y_t <= '0;
      y_f <= '0;
    end else if (load_i) begin
      y_t <= mux_t;
      y_f <= mux_f;
    end
  end

endmodule

// File: rtl/dr_merge_stage.sv
module dr_merge_stage #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [1:0]   sel_rail,
  output logic         sel_ack,
  input  logic [W-1:0] a_t,
  input  logic [W-1:0] a_f,
  output logic         a_ack,
  input  logic [W-1:0] b_t,
  input  logic [W-1:0] b_f,
  output logic         b_ack,
  output logic [W-1:0] y_t,
  output logic [W-1:0] y_f,
  input  logic         y_ack
);

  logic a_full, a_empty, b_full, b_empty;
  logic sel_valid, sel_empty;
  logic load, clear, pick_b_q;
  logic set_s, set_a, set_b, clr_s, clr_a, clr_b;

  assign sel_valid = sel_rail[0] ^ sel_rail[1];
  assign sel_empty = ~(sel_rail[0] | sel_rail[1]);

  dr_rail_detect #(.W(W)) u_det_a (
    .t_i(a_t), .f_i(a_f), .full_o(a_full), .empty_o(a_empty)
  );

  dr_rail_detect #(.W(W)) u_det_b (
    .t_i(b_t), .f_i(b_f), .full_o(b_full), .empty_o(b_empty)
  );

  dr_merge_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .sel_valid  (sel_valid),
    .sel_pick_b (sel_rail[1]),
    .sel_empty  (sel_empty),
    .a_full     (a_full),
    .a_empty    (a_empty),
    .b_full     (b_full),
    .b_empty    (b_empty),
    .y_ack      (y_ack),
    .sel_ack_q  (sel_ack),
    .a_ack_q    (a_ack),
    .b_ack_q    (b_ack),
    .load_o     (load),
    .clear_o    (clear),
    .pick_o     (pick_b_q),
    .set_s_o    (set_s),
    .set_a_o    (set_a),
    .set_b_o    (set_b),
    .clr_s_o    (clr_s),
    .clr_a_o    (clr_a),
    .clr_b_o    (clr_b)
  );

  dr_out_reg #(.W(W)) u_out (
    .clk      (clk),
    .rst      (rst),
    .load_i   (load),
    .clear_i  (clear),
    .pick_b_i (sel_rail[1]),
    .a_t      (a_t),
    .a_f      (a_f),
    .b_t      (b_t),
    .b_f      (b_f),
    .y_t      (y_t),
    .y_f      (y_f)
  );

  dr_ack_unit u_ack_s (
    .clk(clk), .rst(rst), .set_i(set_s), .clr_i(clr_s), .ack_o(sel_ack)
  );

  dr_ack_unit u_ack_a (
    .clk(clk), .rst(rst), .set_i(set_a), .clr_i(clr_a), .ack_o(a_ack)
  );

  dr_ack_unit u_ack_b (
    .clk(clk), .rst(rst), .set_i(set_b), .clr_i(clr_b), .ack_o(b_ack)
  );

  logic unused_pick;
  assign unused_pick = pick_b_q;

endmodule

// File: rtl/dr_merge_stage_chk.sv
module dr_merge_stage_chk #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         rst,
  input logic [1:0]   sel_rail,
  input logic         sel_ack,
  input logic [W-1:0] a_t,
  input logic [W-1:0] a_f,
  input logic         a_ack,
  input logic [W-1:0] b_t,
  input logic [W-1:0] b_f,
  input logic         b_ack,
  input logic [W-1:0] y_t,
  input logic [W-1:0] y_f,
  input logic         y_ack
);

  logic y_any, y_full, a_idle, b_idle;
  assign y_any  = |(y_t | y_f);
  assign y_full = &(y_t ^ y_f);
  assign a_idle = ~|(a_t | a_f);
  assign b_idle = ~|(b_t | b_f);

  // R4
  out_rail_clash_chk: assert property (@(posedge clk) disable iff (rst)
    ~|(y_t & y_f));

  // R6
  one_data_ack_chk: assert property (@(posedge clk) disable iff (rst)
    !(a_ack && b_ack));

  // R5
  a_ack_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(a_ack) |-> (sel_ack && y_full));

  // R5
  b_ack_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(b_ack) |-> (sel_ack && y_full));

  // R2
  out_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(y_any) |-> $past(!y_ack));

  // R7
  out_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(y_any) |-> $past(y_ack));

  // R8
  a_ack_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(a_ack) |-> ($past(a_idle) && !y_any));

  // R8
  b_ack_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(b_ack) |-> ($past(b_idle) && !y_any));

  // R9
  sel_ack_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(sel_ack) |-> ($past(sel_rail == 2'b00) && !y_any));

endmodule

bind dr_merge_stage dr_merge_stage_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .sel_rail(sel_rail), .sel_ack(sel_ack),
  .a_t(a_t), .a_f(a_f), .a_ack(a_ack),
  .b_t(b_t), .b_f(b_f), .b_ack(b_ack),
  .y_t(y_t), .y_f(y_f), .y_ack(y_ack)
);

// File: tb/dr_merge_stage_test.sv
`timescale 1ns/1ps
module dr_merge_stage_test;

  localparam int W = 4;
  localparam int N = 8;
  localparam logic [W-1:0] A_STR [N] = '{4'h3, 4'hA, 4'h0, 4'hF, 4'h5, 4'h9, 4'h6, 4'hC};
  localparam logic [W-1:0] B_STR [N] = '{4'h7, 4'h1, 4'hE, 4'h8, 4'h2, 4'hB, 4'h4, 4'hD};
  // bit i of the select stream: 0 picks A, 1 picks B
  localparam logic [2*N-1:0] SEL_STR = 16'b1011_0010_0110_1001;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [1:0]   sel_rail = 2'b00;
  logic         sel_ack;
  logic [W-1:0] a_t = '0, a_f = '0, b_t = '0, b_f = '0;
  logic         a_ack, b_ack;
  logic [W-1:0] y_t, y_f;
  logic         y_ack = 1'b0;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  dr_merge_stage #(.W(W)) uut (
    .clk(clk), .rst(rst), .sel_rail(sel_rail), .sel_ack(sel_ack),
    .a_t(a_t), .a_f(a_f), .a_ack(a_ack),
    .b_t(b_t), .b_f(b_f), .b_ack(b_ack),
    .y_t(y_t), .y_f(y_f), .y_ack(y_ack)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive_a(input bit v, input logic [W-1:0] d);
    a_t = v ? d : '0;
    a_f = v ? ~d : '0;
  endtask

  task automatic drive_b(input bit v, input logic [W-1:0] d);
    b_t = v ? d : '0;
    b_f = v ? ~d : '0;
  endtask

  function automatic bit out_valid();
    return (&(y_t ^ y_f));
  endfunction

  // Completes one handshake with the inputs already driven.
  task automatic run_token(input bit pick_b, input logic [W-1:0] exp, input bit keep_data);
    logic chosen, other;
    for (int k = 0; k < 40 && !out_valid(); k++) @(negedge clk);
    // R4: value and complement on the rails
    check(out_valid() && y_t == exp && y_f == ~exp, "R4 output token", int'(y_t), int'(exp));
    chosen = pick_b ? b_ack : a_ack;
    // R5: acknowledges still low in the cycle the output appears
    check(!chosen && !sel_ack, "R5 acks low with fresh output", int'({sel_ack, chosen}), 0);
    @(negedge clk);
    chosen = pick_b ? b_ack : a_ack;
    other  = pick_b ? a_ack : b_ack;
    check(chosen && sel_ack, "R5 acks rise together", int'({sel_ack, chosen}), 3);
    // R6: the unselected channel is never acknowledged
    check(!other, "R6 unselected ack low", int'(other), 0);
    sel_rail = 2'b00;
    if (!keep_data) begin
      if (pick_b) drive_b(0, '0); else drive_a(0, '0);
    end
    repeat (3) @(negedge clk);
    // R7: output held while y_ack is low
    check(out_valid() && y_t == exp, "R7 output held", int'(y_t), int'(exp));
    y_ack = 1'b1;
    @(negedge clk);
    check(y_t == '0 && y_f == '0, "R7 output neutral after y_ack", int'({y_t, y_f}), 0);
    chosen = pick_b ? b_ack : a_ack;
    // R8: acknowledges drop only after the output reset
    check(chosen && sel_ack, "R8 acks still high at output reset", int'({sel_ack, chosen}), 3);
    @(negedge clk);
    chosen = pick_b ? b_ack : a_ack;
    check(!sel_ack, "R9 sel ack falls", int'(sel_ack), 0);
    if (!keep_data) check(!chosen, "R8 data ack falls", int'(chosen), 0);
    y_ack = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int ia, ib;
    bit a_loaded, b_loaded;
    logic [W-1:0] exp;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!sel_ack && !a_ack && !b_ack, "R1 acks low in reset", int'({sel_ack, a_ack, b_ack}), 0);
    rst = 1'b0;
    @(negedge clk);
    check(y_t == '0 && y_f == '0 && !sel_ack && !a_ack && !b_ack, "R1 neutral after reset",
          int'({y_t, y_f}), 0);

    // Stream walk against a reference merge (R4, R6)
    ia = 0; ib = 0; a_loaded = 0; b_loaded = 0;
    for (int i = 0; i < 2*N; i++) begin
      if (!a_loaded && ia < N) begin drive_a(1, A_STR[ia]); a_loaded = 1; end
      if (!b_loaded && ib < N) begin drive_b(1, B_STR[ib]); b_loaded = 1; end
      @(negedge clk);
      if (SEL_STR[i]) begin
        exp = B_STR[ib];
        sel_rail = 2'b10;
        run_token(1, exp, 0);
        ib++; b_loaded = 0;
        // R6: token waiting on A was untouched
        if (a_loaded) check(a_t == A_STR[ia] && !a_ack, "R6 waiting A token kept", int'(a_ack), 0);
      end else begin
        exp = A_STR[ia];
        sel_rail = 2'b01;
        run_token(0, exp, 0);
        ia++; a_loaded = 0;
        if (b_loaded) check(b_t == B_STR[ib] && !b_ack, "R6 waiting B token kept", int'(b_ack), 0);
      end
      @(negedge clk);
    end

    // R2: nothing accepted while y_ack is high
    y_ack = 1'b1;
    drive_a(1, 4'h6);
    sel_rail = 2'b01;
    repeat (5) @(negedge clk);
    check(y_t == '0 && y_f == '0 && !sel_ack && !a_ack, "R2 blocked by y_ack", int'(y_t), 0);
    y_ack = 1'b0;
    @(negedge clk);
    check(out_valid() && y_t == 4'h6, "R2 accepted after y_ack low", int'(y_t), 6);
    // R10: inputs still present, yet no second acceptance after return-to-zero
    run_token(0, 4'h6, 0);
    drive_a(1, 4'h9);
    repeat (3) @(negedge clk);
    check(y_t == '0 && y_f == '0, "R10 no token without select", int'(y_t), 0);
    // R3: partial data token not accepted
    drive_a(0, '0);
    a_t = 4'b0001; a_f = 4'b0100;
    sel_rail = 2'b01;
    repeat (4) @(negedge clk);
    check(y_t == '0 && y_f == '0 && !a_ack, "R3 partial token ignored", int'({y_t, y_f}), 0);
    drive_a(1, 4'h5);
    @(negedge clk);
    check(out_valid() && y_t == 4'h5, "R3 accepted once complete", int'(y_t), 5);
    run_token(0, 4'h5, 0);
    @(negedge clk);

    // R9: select returns first while channel B data stays valid
    drive_b(1, 4'hA);
    sel_rail = 2'b10;
    @(negedge clk);
    run_token(1, 4'hA, 1);
    check(b_ack && !sel_ack, "R9 sel ack low, data ack held", int'({sel_ack, b_ack}), 1);
    repeat (3) @(negedge clk);
    check(b_ack, "R8 data ack waits for neutral data", int'(b_ack), 1);
    drive_b(0, '0);
    @(negedge clk);
    check(!b_ack, "R8 data ack falls after data neutral", int'(b_ack), 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule